// File: doc/BRIEF.md
# Prioritised Restart Opcode Responder

This block lets eight peripherals share one non-vectored, maskable interrupt line of a processor. It watches eight request lines and raises the interrupt line while any request is eligible. When the processor acknowledges with an active-low acknowledge strobe, the block drives a single-byte restart opcode onto the data bus. That opcode carries the index of the highest-priority eligible requester, which sends the processor to address index*8.

The winning index is frozen when the acknowledge strobe falls, so a request that arrives later cannot change the byte in the middle of the cycle. When the strobe is released, the block gives the winner a one-cycle, one-hot acknowledge pulse. The winner then stays out of the interrupt line and out of the priority choice until it drops its request. This stops the processor from being interrupted again by a source it has already serviced.

Top module: `restart_opcode_responder`

## Requirements
- R1: During and straight after reset, `intr_o` and `dbus_oe_o` are 0, and `dbus_o` and `ack_o` are all zeros.
- R2: `intr_o` is 1 in the same cycle exactly when at least one request bit is high and that source is not held as serviced (see R8).
- R3: Among the eligible requests, the highest index wins. Source 7 has top priority and source 0 the lowest.
- R4: While the acknowledge strobe is low, `dbus_o` equals {2'b11, winner[2:0], 3'b111}. This is 8'hC7 + 8*winner, the restart that calls address winner*8.
- R5: `dbus_oe_o` is high exactly while `inta_n` is low. While `inta_n` is high, `dbus_o` reads 8'h00.
- R6: The winner is captured at the first clock edge that sees `inta_n` low. For the rest of that low phase the byte stays unchanged, even if a higher request arrives.
- R7: In the first cycle `inta_n` is seen high after a low phase, `ack_o` is the one-hot bit of the captured winner for exactly one cycle. At all other times it is zero.
- R8: A captured winner is held as serviced. It is excluded from R2 and R3 until its request has been low at a clock edge.
- R9: If no request is eligible when the strobe falls, the byte reads 8'hC7 (index 0) and no acknowledge pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Interrupt requests, bit n from source n |
| inta_n | input | 1 | Processor interrupt acknowledge, active low |
| intr_o | output | 1 | Interrupt request to the processor |
| dbus_oe_o | output | 1 | Data bus output enable |
| dbus_o | output | 8 | Restart opcode byte |
| ack_o | output | 8 | One-hot acknowledge pulse to the winning source |

## Verification
`intr_o`, `dbus_oe_o` and the byte in the first strobe-low cycle are combinational, so they are due in the same cycle the inputs change. The bench drives inputs at the falling clock edge and samples one time unit later. The captured byte is due one edge after the strobe falls, so the bench injects a higher request only after that edge. The acknowledge pulse appears in the cycle the strobe returns high. The serviced mask acts from the next edge, and the bench checks both in the cycle after release. It sweeps all 256 request patterns and services the two highest sources of each.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;
    localparam int NUM_SRC = 8;
    localparam int IDX_W   = $clog2(NUM_SRC);

    typedef logic [IDX_W-1:0]   src_idx_t;
    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic     valid;
        src_idx_t idx;
    } pick_t;

    function automatic logic [7:0] restart_byte(input src_idx_t idx);
        return {2'b11, idx, 3'b111};
    endfunction

    function automatic src_vec_t idx_onehot(input src_idx_t idx);
        src_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/prio_pick.sv
module prio_pick
    import irq_resp_pkg::*;
(
    input  src_vec_t eligible,
    output pick_t    pick
);
    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (eligible[i]) begin
                pick.valid = 1'b1;
                pick.idx   = src_idx_t'(i);
            end
        end
    end
endmodule

// File: rtl/ack_cycle_tracker.sv
module ack_cycle_tracker
    import irq_resp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  inta_n,
    input  pick_t live,
    output logic  fall,
    output logic  release_now,
    output logic  in_cycle,
    output pick_t held
);
    logic inta_seen_n;

    assign fall        = !inta_n && inta_seen_n;
    assign release_now = inta_n && in_cycle;

    always_ff @(posedge clk) begin
        if (rst) begin
            inta_seen_n <= 1'b1;
            in_cycle    <= 1'b0;
            held        <= '0;
        end else begin
            inta_seen_n <= inta_n;
            if (fall) begin
                in_cycle <= 1'b1;
                held     <= live;
            end else if (inta_n) begin
                in_cycle <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/service_mask.sv
module service_mask
    import irq_resp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t req,
    input  logic     grab,
    input  pick_t    live,
    output src_vec_t served
);
    src_vec_t set_vec;

    always_comb begin
        set_vec = '0;
        if (grab && live.valid) set_vec = idx_onehot(live.idx);
    end

    always_ff @(posedge clk) begin
        if (rst) served <= '0;
        else     served <= (served & req) | set_vec;
    end
endmodule

// File: rtl/restart_opcode_responder.sv
module restart_opcode_responder
    import irq_resp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] req_i,
    input  logic       inta_n,
    output logic       intr_o,
    output logic       dbus_oe_o,
    output logic [7:0] dbus_o,
    output logic [7:0] ack_o
);
    src_vec_t served;
    src_vec_t eligible;
    pick_t    live;
    pick_t    held;
    logic     fall;
    logic     release_now;
    logic     in_cycle;
    src_idx_t shown;

    assign eligible = req_i & ~served;

    prio_pick u_pick (
        .eligible (eligible),
        .pick     (live)
    );

    ack_cycle_tracker u_trk (
        .clk         (clk),
        .rst         (rst),
        .inta_n      (inta_n),
        .live        (live),
        .fall        (fall),
        .release_now (release_now),
        .in_cycle    (in_cycle),
        .held        (held)
    );

    service_mask u_mask (
        .clk    (clk),
        .rst    (rst),
        .req    (req_i),
        .grab   (fall),
        .live   (live),
        .served (served)
    );

    assign shown = in_cycle ? held.idx : live.idx;

    always_comb begin
        intr_o    = !rst && (|eligible);
        dbus_oe_o = !rst && !inta_n;
        dbus_o    = dbus_oe_o ? restart_byte(shown) : 8'h00;
        ack_o     = (!rst && release_now && held.valid) ? idx_onehot(held.idx) : '0;
    end
endmodule

// File: rtl/restart_opcode_checker.sv
module restart_opcode_checker (
    input logic       clk,
    input logic       rst,
    input logic       inta_n,
    input logic [7:0] req_i,
    input logic       intr_o,
    input logic       dbus_oe_o,
    input logic [7:0] dbus_o,
    input logic [7:0] ack_o
);
    p_bus_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !dbus_oe_o |-> dbus_o == 8'h00);

    p_byte_form_r4: assert property (@(posedge clk) disable iff (rst)
        dbus_oe_o |-> (dbus_o[7:6] == 2'b11 && dbus_o[2:0] == 3'b111));

    p_byte_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (!inta_n && $past(!inta_n) && !$past(rst)) |-> $stable(dbus_o));

    p_ack_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_o));

    p_ack_single_r7: assert property (@(posedge clk) disable iff (rst)
        (|ack_o) |=> ack_o == 8'h00);

    p_ack_off_bus_r7: assert property (@(posedge clk) disable iff (rst)
        (|ack_o) |-> !dbus_oe_o);

    p_intr_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        intr_o |-> (|req_i));
endmodule

bind restart_opcode_responder restart_opcode_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .inta_n    (inta_n),
    .req_i     (req_i),
    .intr_o    (intr_o),
    .dbus_oe_o (dbus_oe_o),
    .dbus_o    (dbus_o),
    .ack_o     (ack_o)
);

// File: tb/tb_restart_opcode_responder.sv
`timescale 1ns/1ps
module tb_restart_opcode_responder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_i = 8'h00;
    logic       inta_n = 1'b1;
    logic       intr_o;
    logic       dbus_oe_o;
    logic [7:0] dbus_o;
    logic [7:0] ack_o;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    restart_opcode_responder dut (
        .clk(clk), .rst(rst), .req_i(req_i), .inta_n(inta_n),
        .intr_o(intr_o), .dbus_oe_o(dbus_oe_o), .dbus_o(dbus_o), .ack_o(ack_o)
    );

    function automatic int top_idx(input logic [7:0] v);
        int r = -1;
        for (int i = 0; i < 8; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic logic [7:0] exp_byte(input int idx);
        return 8'(199 + 8 * idx);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic serve(input logic [7:0] pat, input logic [7:0] elig);
        int w;
        w = top_idx(elig);
        step(); inta_n = 1'b0; #1;
        chk("R5 oe low phase", {7'b0, dbus_oe_o}, 8'h01);
        chk("R3 R4 live byte", dbus_o, exp_byte(w < 0 ? 0 : w));
        step();
        if (w >= 0 && w < 7) req_i = pat | 8'h80;
        #1;
        chk("R6 frozen byte", dbus_o, exp_byte(w < 0 ? 0 : w));
        chk("R9 R6 oe held", {7'b0, dbus_oe_o}, 8'h01);
        step(); req_i = pat; inta_n = 1'b1; #1;
        chk("R7 R9 ack pulse", ack_o, w < 0 ? 8'h00 : 8'(1 << w));
        chk("R5 released", {dbus_oe_o, 7'b0} | dbus_o, 8'h00);
        step(); #1;
        chk("R7 ack one cycle", ack_o, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rem;
        repeat (3) step();
        #1;
        chk("R1 reset outputs", {intr_o, dbus_oe_o, 6'b0}, 8'h00);
        chk("R1 reset bus", dbus_o, 8'h00);
        chk("R1 reset ack", ack_o, 8'h00);
        step(); rst = 1'b0; #1;
        chk("R1 after reset ack", ack_o, 8'h00);
        for (int p = 0; p < 256; p++) begin
            step(); req_i = 8'(p); inta_n = 1'b1; #1;
            chk("R2 intr", {7'b0, intr_o}, {7'b0, (p != 0)});
            chk("R5 bus idle", dbus_o, 8'h00);
            serve(8'(p), 8'(p));
            rem = (p == 0) ? 8'h00 : (8'(p) & ~8'(1 << top_idx(8'(p))));
            chk("R8 R2 intr after service", {7'b0, intr_o}, {7'b0, (rem != 0)});
            if (rem != 0) begin
                serve(8'(p), rem);
                rem = rem & ~8'(1 << top_idx(rem));
                chk("R8 intr after second", {7'b0, intr_o}, {7'b0, (rem != 0)});
            end
            step(); req_i = 8'h00; #1;
            chk("R2 intr clear", {7'b0, intr_o}, 8'h00);
        end
        step(); req_i = 8'h05; #1;
        chk("R8 mask released", {7'b0, intr_o}, 8'h01);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule